// File: doc/BRIEF.md
# Auto-Reload Baud and Clock-Out Timer

This block is a 16-bit up-counter paired with a 16-bit reload register. Whenever the counter passes its all-ones value, it reloads from that register. Software sets it up through a small byte-wide register bus: one control register, one mode register, and byte access to the counter and to the reload value. The block has two special uses. It can act as a bit-rate generator that sends one-cycle ticks to a serial port's transmitter, its receiver or both. It can also drive a square wave with a 50% duty cycle onto an output pin. Both uses can run together, and they share the one reload value.

The rate at which the counter advances depends on the mode. In either special mode the counter steps once every two clocks. In plain timer mode it steps once every twelve clocks. A rollover in a special mode reloads the counter without raising a flag. In plain mode the same rollover sets an overflow flag that drives the interrupt output. A falling edge on the external trigger pin always sets a flag when it is enabled. The edge reloads the counter only in plain mode, so in the special modes the pin serves as a spare interrupt source.

Top module: `brt_timer`

## Requirements
- R1: After reset, every register (addresses 0 to 5) reads 0, and the tick, clock-out and interrupt outputs are 0.
- R2: The counter steps once every 12 clocks in plain mode. It steps once every 2 clocks when transmit select (control bit 2), receive select (control bit 3) or clock-out enable (mode bit 0) is set. Counting starts 12 or 2 clocks after the run bit (control bit 0) is written to 1.
- R3: When the counter steps from 0xFFFF, it loads the reload value (low byte at address 4, high byte at address 5). The overflow flag (control bit 5) and the interrupt are set only in plain mode.
- R4: In bit-rate mode, every 16th rollover gives a one-clock pulse. The pulse appears on the transmit tick if transmit select is set, and on the receive tick if receive select is set. Consecutive pulses are 32 x (65536 - reload) clocks apart.
- R5: With clock-out enabled and the count-source bit (control bit 6) clear, the clock-out pin toggles on every rollover, which gives a 50% square wave. Otherwise the pin is 0.
- R6: Set the external enable (control bit 1), then drive a falling edge on the trigger pin. This sets the external flag (control bit 4) and the interrupt in every mode. The edge reloads the counter in plain mode only.
- R7: While the run bit and a select bit are both set, writes to the counter bytes (addresses 2, 3) and to the reload bytes (addresses 4, 5) have no effect.
- R8: With the run bit clear, the counter holds its value.
- R9: A control write sets both flags to the written bits, so writing 0 clears them. The interrupt output is the OR of the two flags.
- R10: With the count-source bit set, the counter does not advance and the clock-out pin stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| ext_pin_i | input | 1 | External trigger pin, falling-edge sensitive |
| tx_tick_o | output | 1 | Transmit bit-rate tick |
| rx_tick_o | output | 1 | Receive bit-rate tick |
| clk_out_o | output | 1 | Square-wave clock output |
| irq_o | output | 1 | Interrupt, OR of the two flags |

## Verification
The block is run in five patterns: plain mode with a near-rollover preset, bit-rate mode with both directions selected, transmit only, clock-out alone, and clock-out with bit-rate. Plain mode against the special modes separates the two step rates and shows whether the overflow flag is raised or suppressed. Transmit-only against both directions checks that each select bit gates its own tick. Clock-out with and without bit-rate shows that the shared reload value sets the toggle spacing whether or not ticks are also generated. Trigger-pin edges are applied in plain mode and in bit-rate mode, to separate a reload from a flag-only event.

// File: rtl/brt_pkg.sv
`timescale 1ns/1ps
package brt_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADR_CTRL   = 3'd0,
    ADR_MODE   = 3'd1,
    ADR_CNT_LO = 3'd2,
    ADR_CNT_HI = 3'd3,
    ADR_RLD_LO = 3'd4,
    ADR_RLD_HI = 3'd5
  } reg_addr_e;

  // bit 6 down to bit 0
  typedef struct packed {
    logic cnt_sel;
    logic ovf_f;
    logic ext_f;
    logic rx_sel;
    logic tx_sel;
    logic ext_en;
    logic run;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/brt_regs.sv
`timescale 1ns/1ps
module brt_regs
  import brt_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DW-1:0]       wdata_i,
  input  logic                roll_i,
  input  logic                fast_i,
  input  logic                ext_fall_i,
  input  logic [2*DW-1:0]     cnt_i,
  output ctrl_t               ctrl_o,
  output logic                ckoe_o,
  output logic [2*DW-1:0]     rld_o,
  output logic [1:0]          cnt_wr_o,
  output logic [DW-1:0]       rdata_o
);
  ctrl_t                ctrl_q;
  ctrl_t                ctrl_wv;
  logic                 ckoe_q;
  logic [1:0][DW-1:0]   rld_q;
  logic [1:0]           rld_wr;
  logic                 prot;
  logic                 wr_ctrl;
  logic                 wr_mode;

  assign prot    = ctrl_q.run & (ctrl_q.tx_sel | ctrl_q.rx_sel);
  assign wr_ctrl = wr_en_i && (addr_i == ADR_CTRL);
  assign wr_mode = wr_en_i && (addr_i == ADR_MODE);
  assign ctrl_wv = ctrl_t'(wdata_i[CTRL_W-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      ckoe_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.cnt_sel <= ctrl_wv.cnt_sel;
        ctrl_q.rx_sel  <= ctrl_wv.rx_sel;
        ctrl_q.tx_sel  <= ctrl_wv.tx_sel;
        ctrl_q.ext_en  <= ctrl_wv.ext_en;
        ctrl_q.run     <= ctrl_wv.run;
      end
      // hardware set wins over a software write
      ctrl_q.ext_f <= (wr_ctrl ? ctrl_wv.ext_f : ctrl_q.ext_f) | (ext_fall_i & ctrl_q.ext_en);
      ctrl_q.ovf_f <= (wr_ctrl ? ctrl_wv.ovf_f : ctrl_q.ovf_f) | (roll_i & ~fast_i);
      if (wr_mode) ckoe_q <= wdata_i[0];
    end
  end

  for (genvar b = 0; b < 2; b++) begin : g_lane
    assign rld_wr[b]   = wr_en_i && !prot && (addr_i == ADDR_W'(ADR_RLD_LO) + ADDR_W'(b));
    assign cnt_wr_o[b] = wr_en_i && !prot && (addr_i == ADDR_W'(ADR_CNT_LO) + ADDR_W'(b));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        rld_q[b] <= '0;
      else if (rld_wr[b]) rld_q[b] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADR_CTRL:   rdata_o[CTRL_W-1:0] = ctrl_q;
      ADR_MODE:   rdata_o[0]          = ckoe_q;
      ADR_CNT_LO: rdata_o             = cnt_i[DW-1:0];
      ADR_CNT_HI: rdata_o             = cnt_i[2*DW-1:DW];
      ADR_RLD_LO: rdata_o             = rld_q[0];
      ADR_RLD_HI: rdata_o             = rld_q[1];
      default:    rdata_o             = '0;
    endcase
  end

  assign ctrl_o = ctrl_q;
  assign ckoe_o = ckoe_q;
  assign rld_o  = rld_q;

  p_no_ovf_fast_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fast_i && !wr_ctrl) |=> !$rose(ctrl_q.ovf_f));
  p_ext_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_fall_i && ctrl_q.ext_en) |=> ctrl_q.ext_f);
  p_protect_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && prot && (addr_i == ADR_RLD_LO || addr_i == ADR_RLD_HI)) |=> $stable(rld_q));
endmodule

// File: rtl/brt_core.sv
`timescale 1ns/1ps
module brt_core #(
  parameter int DW       = 8,
  parameter int SLOW_DIV = 12,
  parameter int FAST_DIV = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              fast_i,
  input  logic              ext_reload_i,
  input  logic [1:0]        cnt_wr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [2*DW-1:0]   rld_i,
  output logic [2*DW-1:0]   cnt_o,
  output logic              roll_o
);
  localparam int CW     = 2 * DW;
  localparam int MAXDIV = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
  localparam int PW     = (MAXDIV > 2) ? $clog2(MAXDIV) : 1;

  logic [PW-1:0]        pre_q;
  logic [PW-1:0]        pre_last;
  logic                 step;
  logic [CW-1:0]        cnt_q;
  logic [CW-1:0]        base;
  logic [1:0][DW-1:0]   cnt_nx;

  assign pre_last = fast_i ? PW'(FAST_DIV - 1) : PW'(SLOW_DIV - 1);
  assign step     = run_i && (pre_q >= pre_last);
  assign roll_o   = step && (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pre_q <= '0;
    else if (!run_i) pre_q <= '0;
    else if (step)   pre_q <= '0;
    else             pre_q <= pre_q + 1'b1;
  end

  always_comb begin
    if (|cnt_wr_i)         base = cnt_q;
    else if (ext_reload_i) base = rld_i;
    else if (step)         base = (&cnt_q) ? rld_i : cnt_q + 1'b1;
    else                   base = cnt_q;
  end

  for (genvar b = 0; b < 2; b++) begin : g_lane
    assign cnt_nx[b] = cnt_wr_i[b] ? wdata_i : base[b*DW +: DW];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_nx;
  end

  assign cnt_o = cnt_q;

  p_step_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step |=> !step);
  p_roll_reload_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (roll_o && cnt_wr_i == 2'b00) |=> cnt_q == $past(rld_i));
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && cnt_wr_i == 2'b00 && !ext_reload_i) |=> $stable(cnt_q));
endmodule

// File: rtl/brt_edge.sv
`timescale 1ns/1ps
module brt_edge #(
  parameter int SYNC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic fall_o
);
  logic [SYNC:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '1;
    else         sr_q <= {sr_q[SYNC-1:0], pin_i};
  end

  assign fall_o = sr_q[SYNC] & ~sr_q[SYNC-1];

  p_fall_once_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/brt_outgen.sv
`timescale 1ns/1ps
module brt_outgen #(
  parameter int TICK_DIV = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic roll_i,
  input  logic tx_sel_i,
  input  logic rx_sel_i,
  input  logic ck_en_i,
  output logic tx_tick_o,
  output logic rx_tick_o,
  output logic clk_o
);
  localparam int SW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [SW-1:0] SUB_LAST = SW'(TICK_DIV - 1);

  logic [SW-1:0] sub_q;
  logic          baud;
  logic          tick;
  logic          tx_q, rx_q, clk_q;

  assign baud = tx_sel_i | rx_sel_i;
  assign tick = roll_i && baud && (sub_q == SUB_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sub_q <= '0;
      tx_q  <= 1'b0;
      rx_q  <= 1'b0;
      clk_q <= 1'b0;
    end else begin
      if (!baud)       sub_q <= '0;
      else if (roll_i) sub_q <= (sub_q == SUB_LAST) ? '0 : sub_q + 1'b1;
      tx_q <= tick & tx_sel_i;
      rx_q <= tick & rx_sel_i;
      if (!ck_en_i)    clk_q <= 1'b0;
      else if (roll_i) clk_q <= ~clk_q;
    end
  end

  assign tx_tick_o = tx_q;
  assign rx_tick_o = rx_q;
  assign clk_o     = clk_q;

  p_tick_src_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_tick_o || rx_tick_o) |-> $past(roll_i));
  p_clk_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ck_en_i && !roll_i) |=> ($stable(clk_q) || !ck_en_i));
endmodule

// File: rtl/brt_timer.sv
`timescale 1ns/1ps
module brt_timer
  import brt_pkg::*;
#(
  parameter int DW       = 8,
  parameter int SLOW_DIV = 12,
  parameter int FAST_DIV = 2,
  parameter int TICK_DIV = 16,
  parameter int SYNC     = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic              ext_pin_i,
  output logic              tx_tick_o,
  output logic              rx_tick_o,
  output logic              clk_out_o,
  output logic              irq_o
);
  ctrl_t            ctrl;
  logic             ckoe;
  logic [2*DW-1:0]  rld;
  logic [2*DW-1:0]  cnt;
  logic [1:0]       cnt_wr;
  logic             roll;
  logic             ext_fall;
  logic             fast;
  logic             run;
  logic             ext_reload;

  assign fast       = ctrl.tx_sel | ctrl.rx_sel | ckoe;
  assign run        = ctrl.run & ~ctrl.cnt_sel;
  assign ext_reload = ext_fall & ctrl.ext_en & ~fast;

  brt_regs #(.DW(DW)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .roll_i(roll), .fast_i(fast), .ext_fall_i(ext_fall), .cnt_i(cnt),
    .ctrl_o(ctrl), .ckoe_o(ckoe), .rld_o(rld), .cnt_wr_o(cnt_wr), .rdata_o
  );

  brt_core #(.DW(DW), .SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) u_core (
    .clk_i, .rst_ni, .run_i(run), .fast_i(fast), .ext_reload_i(ext_reload),
    .cnt_wr_i(cnt_wr), .wdata_i, .rld_i(rld), .cnt_o(cnt), .roll_o(roll)
  );

  brt_edge #(.SYNC(SYNC)) u_edge (
    .clk_i, .rst_ni, .pin_i(ext_pin_i), .fall_o(ext_fall)
  );

  brt_outgen #(.TICK_DIV(TICK_DIV)) u_out (
    .clk_i, .rst_ni, .roll_i(roll), .tx_sel_i(ctrl.tx_sel), .rx_sel_i(ctrl.rx_sel),
    .ck_en_i(ckoe & ~ctrl.cnt_sel), .tx_tick_o, .rx_tick_o, .clk_o(clk_out_o)
  );

  assign irq_o = ctrl.ovf_f | ctrl.ext_f;
endmodule

// File: tb/brt_timer_bench.sv
`timescale 1ns/1ps
module brt_timer_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'd0;
  logic       ext_pin = 1'b1;
  logic [7:0] rdata;
  logic       tx_tick, rx_tick, clk_out, irq;

  always #5 clk_i = ~clk_i;

  brt_timer u_brt_timer (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .ext_pin_i(ext_pin), .tx_tick_o(tx_tick), .rx_tick_o(rx_tick),
    .clk_out_o(clk_out), .irq_o(irq)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  // behavioural reference state
  int m_cnt, m_rld, m_pre, m_sub;
  bit m_run, m_exen, m_tx, m_rx, m_ef, m_of, m_cs, m_ckoe, m_clk, m_txt, m_rxt;
  bit h0, h1, h2;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int m_rdata(input int a);
    case (a)
      0: return {m_cs, m_of, m_ef, m_rx, m_tx, m_exen, m_run};
      1: return int'(m_ckoe);
      2: return m_cnt & 'hFF;
      3: return (m_cnt >> 8) & 'hFF;
      4: return m_rld & 'hFF;
      5: return (m_rld >> 8) & 'hFF;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt = 0; m_rld = 0; m_pre = 0; m_sub = 0;
      m_run = 0; m_exen = 0; m_tx = 0; m_rx = 0; m_ef = 0; m_of = 0; m_cs = 0;
      m_ckoe = 0; m_clk = 0; m_txt = 0; m_rxt = 0;
      h0 = 1; h1 = 1; h2 = 1;
    end else begin : model
      bit baud, fast, run, fall, prot, step, roll, wc, tick;
      int dv, nc;
      baud = m_tx | m_rx;
      fast = baud | m_ckoe;
      run  = m_run & !m_cs;
      dv   = fast ? 2 : 12;
      fall = h2 & !h1;
      prot = m_run & baud;
      step = run && (m_pre >= dv - 1);
      roll = step && (m_cnt == 65535);
      wc   = wr_en && (addr == 0);
      nc   = m_cnt;
      if (wr_en && !prot && addr == 2)      nc = (m_cnt & 'hFF00) | int'(wdata);
      else if (wr_en && !prot && addr == 3) nc = (m_cnt & 'h00FF) | (int'(wdata) << 8);
      else if (fall && m_exen && !fast)     nc = m_rld;
      else if (step)                        nc = roll ? m_rld : m_cnt + 1;
      if (wr_en && !prot && addr == 4) m_rld = (m_rld & 'hFF00) | int'(wdata);
      if (wr_en && !prot && addr == 5) m_rld = (m_rld & 'h00FF) | (int'(wdata) << 8);
      m_pre = !run ? 0 : (step ? 0 : m_pre + 1);
      tick  = roll && baud && (m_sub == 15);
      m_txt = tick & m_tx;
      m_rxt = tick & m_rx;
      if (!baud)     m_sub = 0;
      else if (roll) m_sub = (m_sub == 15) ? 0 : m_sub + 1;
      if (!(m_ckoe && !m_cs)) m_clk = 0;
      else if (roll)          m_clk = !m_clk;
      m_ef = (wc ? wdata[4] : m_ef) | (fall & m_exen);
      m_of = (wc ? wdata[5] : m_of) | (roll & !fast);
      if (wc) begin
        m_run = wdata[0]; m_exen = wdata[1]; m_tx = wdata[2]; m_rx = wdata[3]; m_cs = wdata[6];
      end
      if (wr_en && addr == 1) m_ckoe = wdata[0];
      m_cnt = nc;
      h2 = h1; h1 = h0; h0 = ext_pin;
    end
  end

  // per-cycle comparison against the reference, away from the active edge
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      chk("R2/R3 rdata vs model", int'(rdata), m_rdata(int'(addr)));
      chk("R5 clk_out vs model", int'(clk_out), int'(m_clk));
      chk("R4 tx_tick vs model", int'(tx_tick), int'(m_txt));
      chk("R4 rx_tick vs model", int'(rx_tick), int'(m_rxt));
      chk("R9 irq vs model", int'(irq), int'(m_of | m_ef));
    end
  end

  always @(posedge clk_i) cyc++;

  task automatic wr(input int a, input int d);
    @(posedge clk_i); #1;
    wr_en = 1'b1; addr = 3'(a); wdata = 8'(d);
    @(posedge clk_i); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    addr = 3'(a);
    #2;
    v = int'(rdata);
  endtask

  task automatic rd_chk(input string tag, input int a, input int exp);
    int v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic wait_toggle(output int t);
    logic v;
    v = clk_out;
    do @(negedge clk_i); while (clk_out == v);
    t = cyc;
  endtask

  task automatic wait_tx(output int t);
    do @(negedge clk_i); while (!tx_tick);
    t = cyc;
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    finish_run();
  end

  initial begin
    int v1, v2, t1, t2, t3, cnt_rx, cnt_tx;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    #1;
    // R1 reset state
    for (int a = 0; a < 6; a++) rd_chk("R1 reset register", a, 0);
    chk("R1 reset tx_tick", int'(tx_tick), 0);
    chk("R1 reset rx_tick", int'(rx_tick), 0);
    chk("R1 reset clk_out", int'(clk_out), 0);
    chk("R1 reset irq", int'(irq), 0);

    // R2 plain-mode rate: 5 steps in 60 clocks
    wr(0, 'h01);
    idle(60);
    rd_chk("R2 plain step rate", 2, 5);
    // R8 hold while stopped
    wr(0, 'h00);
    rd(2, v1);
    idle(20);
    rd(2, v2);
    chk("R8 counter holds when stopped", v2, v1);

    // R2 fast rate: 5 steps in 10 clocks
    wr(2, 0); wr(3, 0); wr(1, 1); wr(0, 'h01);
    idle(10);
    rd_chk("R2 fast step rate", 2, 5);
    wr(0, 0); wr(1, 0);

    // R3 plain-mode rollover sets overflow
    wr(4, 'hF0); wr(5, 'hFF); wr(2, 'hFE); wr(3, 'hFF); wr(0, 'h01);
    idle(40);
    rd_chk("R3 overflow flag in plain mode", 0, 'h21);
    chk("R3 irq on overflow", int'(irq), 1);
    rd_chk("R3 reload after rollover", 2, 'hF1);
    wr(0, 'h01);
    rd_chk("R9 flag cleared by write", 0, 'h01);
    chk("R9 irq cleared", int'(irq), 0);

    // R6 plain-mode trigger edge reloads
    wr(0, 0); wr(2, 0); wr(3, 0); wr(0, 'h02);
    ext_pin = 1'b0;
    idle(5);
    rd_chk("R6 plain edge reload lo", 2, 'hF0);
    rd_chk("R6 plain edge reload hi", 3, 'hFF);
    rd_chk("R6 ext flag set", 0, 'h12);
    ext_pin = 1'b1;
    wr(0, 0);
    rd_chk("R9 ext flag cleared", 0, 0);

    // R4 bit-rate mode, both directions
    wr(2, 'hFE); wr(3, 'hFF); wr(4, 'hFE); wr(5, 'hFF); wr(0, 'h0F);
    wait_tx(t1);
    wait_tx(t2);
    chk("R4 tick spacing 32*(65536-reload)", t2 - t1, 64);
    chk("R4 rx tick with tx tick", int'(rx_tick), 1);
    #1;
    wr(4, 'h00);
    rd_chk("R7 reload write ignored while running", 4, 'hFE);
    wr(2, 'h55);
    addr = 3'd2;
    ext_pin = 1'b0;
    idle(5);
    rd_chk("R6 edge flag set, no overflow (R3)", 0, 'h1F);
    ext_pin = 1'b1;
    idle(3);

    // R4 transmit only
    wr(0, 'h07);
    cnt_rx = 0; cnt_tx = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk_i);
      if (rx_tick) cnt_rx++;
      if (tx_tick) cnt_tx++;
    end
    chk("R4 no rx tick when rx unselected", cnt_rx, 0);
    chk("R4 tx tick present", int'(cnt_tx > 0), 1);

    // R5 clock-out alone
    #1;
    wr(0, 0); wr(1, 1); wr(2, 'hFD); wr(3, 'hFF); wr(4, 'hFD); wr(5, 'hFF); wr(0, 'h01);
    wait_toggle(t1); wait_toggle(t2); wait_toggle(t3);
    chk("R5 clock-out half period", t3 - t2, 6);
    // R5 clock-out with bit-rate at once
    #1;
    wr(0, 'h05);
    wait_toggle(t1); wait_toggle(t2); wait_toggle(t3);
    chk("R5 clock-out half period with baud", t3 - t2, 6);

    // R10 count-source bit stops counting and clock-out
    #1;
    wr(0, 'h41);
    idle(3);
    chk("R10 clk_out low", int'(clk_out), 0);
    rd(2, v1);
    idle(30);
    rd(2, v2);
    chk("R10 counter frozen", v2, v1);

    idle(2);
    finish_run();
  end
endmodule